// File: doc/BRIEF.md
# Flash Code Protect Controller

This block holds the one-byte protection setting kept in the top location of an on-chip flash array. From that byte it decides whether an external programmer on the parallel port may read or rewrite the flash. Software or a serial loader changes the byte with write strobes. A write can only clear bits. Only an erase of the flash block that holds the byte sets bits back to 1. An active-low synchronous reset loads 0xFF, which models a blank part.

Two 2-bit fields in the byte must agree before protection takes hold. The unlock field (bits 5:4) cannot be changed while the device is in parallel I/O mode. Each read or program request from the parallel port gets exactly one grant or deny pulse on the next clock cycle.

Top module: `flash_guard`

## Requirements
- R1: After reset or after an erase pulse, `prot_byte` reads 0xFF.
- R2: Bits 3:0 of `prot_byte` stay 1 whatever data is written.
- R3: A write stores old AND `wr_data`, so a write can clear bits but never set them.
- R4: A write made while `par_mode` is 1 leaves bits 5:4 unchanged. Bits 7:6 still take the AND.
- R5: `prot_active` is 1 exactly when bits 5:4 are not 00 and bits 7:6 are not 11.
- R6: Writing 00 into bits 5:4 outside parallel mode clears `prot_active`.
- R7: A read or program request made with `par_mode`=1 while `prot_active`=1 gives a one-cycle deny pulse on the next cycle and no grant.
- R8: Every other request gives a one-cycle grant pulse on the next cycle. A cycle with no request gives neither pulse, and a grant and a deny are never high together.
- R9: An erase in the same cycle as a write wins, and the byte becomes 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_mode | input | 1 | 1 while the device is in parallel I/O mode |
| wr_en | input | 1 | Write strobe for the protection byte |
| wr_data | input | 8 | Write data; its 0 bits clear the matching bits of the byte |
| erase | input | 1 | Erase pulse for the block holding the byte |
| rd_req | input | 1 | Parallel-port read request |
| pg_req | input | 1 | Parallel-port program request |
| prot_byte | output | 8 | Current protection byte |
| prot_active | output | 1 | Protection currently in force |
| rd_grant | output | 1 | Read granted (one cycle after the request) |
| rd_deny | output | 1 | Read refused (one cycle after the request) |
| pg_grant | output | 1 | Program granted (one cycle after the request) |
| pg_deny | output | 1 | Program refused (one cycle after the request) |

## Verification
A write or an erase shows up on `prot_byte` and `prot_active` one clock after the strobe. A grant or deny pulse follows its request by one clock and is judged on the byte as it stood in the request cycle, before any write in that same cycle.

The driver task applies one stimulus per cycle on the falling edge. It advances its own model of the byte and queues the expected byte, flag and four response bits. The monitor pops one entry a short delay after each rising edge and compares it with the outputs, so every result is checked in exactly the cycle it is due.

// File: rtl/flash_guard.sv
module flash_guard (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       par_mode,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       erase,
  input  logic       rd_req,
  input  logic       pg_req,
  output logic [7:0] prot_byte,
  output logic       prot_active,
  output logic       rd_grant,
  output logic       rd_deny,
  output logic       pg_grant,
  output logic       pg_deny
);

  logic [7:0] byte_q;
  logic [7:0] wmask;
  logic       refuse;

  assign wmask       = {wr_data[7:6], par_mode ? 2'b11 : wr_data[5:4], 4'hF};
  assign prot_active = (byte_q[5:4] != 2'b00) && (byte_q[7:6] != 2'b11);
  assign refuse      = par_mode && prot_active;
  assign prot_byte   = byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n || erase)
      byte_q <= 8'hFF;
    else if (wr_en)
      byte_q <= byte_q & wmask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_grant <= 1'b0;
      rd_deny  <= 1'b0;
      pg_grant <= 1'b0;
      pg_deny  <= 1'b0;
    end else begin
      rd_grant <= rd_req && !refuse;
      rd_deny  <= rd_req && refuse;
      pg_grant <= pg_req && !refuse;
      pg_deny  <= pg_req && refuse;
    end
  end

  // R2
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> byte_q[3:0] == 4'hF);

  // R3
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(erase)) |-> (byte_q & ~$past(byte_q)) == 8'h00);

  // R4
  field_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(par_mode) && !$past(erase)) |-> byte_q[5:4] == $past(byte_q[5:4]));

  // R9
  erase_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> byte_q == 8'hFF);

  // R7
  rd_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && par_mode && prot_active) |=> (rd_deny && !rd_grant));

  // R7
  pg_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_req && par_mode && prot_active) |=> (pg_deny && !pg_grant));

  // R8
  rd_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> $countones({rd_grant, rd_deny}) == 1);

  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_req && !pg_req) |=> !(rd_grant || rd_deny || pg_grant || pg_deny));

  // R8
  pg_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_grant && pg_deny));

endmodule

// File: tb/tb_flash_guard.sv
module tb_flash_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_mode = 1'b0, wr_en = 1'b0, erase = 1'b0, rd_req = 1'b0, pg_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] prot_byte;
  logic       prot_active, rd_grant, rd_deny, pg_grant, pg_deny;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0]  m = 8'hFF;
  logic [12:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  flash_guard dut (.*);

  function automatic logic act(input logic [7:0] b);
    return (b[5:4] != 2'b00) && (b[7:6] != 2'b11);
  endfunction

  task automatic step(input string tag, input logic par, input logic we, input logic [7:0] wd,
                      input logic er, input logic rr, input logic pr);
    logic [7:0] nb;
    logic       ref_;
    @(negedge clk);
    par_mode = par; wr_en = we; wr_data = wd; erase = er; rd_req = rr; pg_req = pr;
    ref_ = par && act(m);
    nb = er ? 8'hFF : (we ? (m & {wd[7:6], par ? 2'b11 : wd[5:4], 4'hF}) : m);
    q_exp.push_back({nb, act(nb), rr && !ref_, rr && ref_, pr && !ref_, pr && ref_});
    q_tag.push_back(tag);
    m = nb;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && q_exp.size() > 0) begin
        logic [12:0] e, a;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = {prot_byte, prot_active, rd_grant, rd_deny, pg_grant, pg_deny};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, a, e);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    checks++;
    if (prot_byte !== 8'hFF || prot_active !== 1'b0 || rd_grant !== 1'b0 || pg_deny !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got %h/%b expected ff/0", prot_byte, prot_active);
    end
    step("R8 serial read grant",        0, 0, 8'h00, 0, 1, 0);
    step("R8 blank parallel read",      1, 0, 8'h00, 0, 1, 1);
    step("R8 idle no pulse",            0, 0, 8'h00, 0, 0, 0);
    step("R5 set protect 0x5F",         0, 1, 8'h5F, 0, 0, 0);
    step("R7 parallel read deny",       1, 0, 8'h00, 0, 1, 0);
    step("R7 parallel program deny",    1, 0, 8'h00, 0, 0, 1);
    step("R8 serial grant when locked", 0, 0, 8'h00, 0, 1, 1);
    step("R2 low nibble stays set",     0, 1, 8'hF0, 0, 0, 0);
    step("R3 no bit set by write",      0, 1, 8'hFF, 0, 0, 0);
    step("R4 frozen field in parallel", 1, 1, 8'hCF, 0, 1, 0);
    step("R7 still locked",             1, 0, 8'h00, 0, 0, 1);
    step("R6 unlock field to 00",       0, 1, 8'hCF, 0, 0, 0);
    step("R8 unlocked parallel read",   1, 0, 8'h00, 0, 1, 1);
    step("R9 erase beats write",        0, 1, 8'h00, 1, 0, 0);
    step("R5 level field 11 no lock",   0, 1, 8'hEF, 0, 0, 0);
    step("R5 parallel read level 11",   1, 0, 8'h00, 0, 1, 0);
    step("R5 clear level field",        0, 1, 8'h3F, 0, 0, 0);
    step("R7 deny both requests",       1, 0, 8'h00, 0, 1, 1);
    step("R1 erase restores ff",        1, 0, 8'h00, 1, 0, 0);
    step("R8 grant after erase",        1, 0, 8'h00, 0, 1, 1);
    step("R8 idle tail",                0, 0, 8'h00, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule